// File: doc/BRIEF.md
# GPIO Port with Interrupt-on-Change

An eight-pin general-purpose I/O port sitting behind a plain single-cycle register bus. Each pin can be set as an input or an output, can have its read value inverted, and can request a pull-up. Output pins drive the value held in an output latch. Input pins are brought into the clock domain through two flops before any use.

An interrupt unit watches the enabled pins. Each pin is set to one of two modes. In the first mode it fires when the pin differs from its previous sample. In the second mode it fires when the pin differs from a programmed default bit. When the unit fires, it records one cause bit for the lowest-numbered triggering pin and takes a snapshot of the whole port. It then holds both until software acknowledges the interrupt. The acknowledge is a read of either the port register or the capture register, chosen by a configuration bit. The interrupt output can be set active-high, active-low or open-drain.

Top module: `gpio_ioc_port`

## Requirements
- R1: After reset the direction register reads 0xFF, the other writable registers read 0x00, no pin is driven (`pin_oe` = 0), and the interrupt output is inactive: push-pull and active-low, so `irq_o` = 1 and `irq_oe` = 1.
- R2: Writable registers read back what was written. The addresses are: 0x0 direction, 0x1 polarity, 0x2 interrupt enable, 0x3 default value, 0x4 mode select, 0x5 configuration, 0x6 pull-up, 0xA output latch. Configuration keeps only bits 2:0 and reads 0 in bits 7:3.
- R3: A direction bit of 1 makes its pin an input and 0 makes it an output (`pin_oe` bit = 1). `pin_out` follows the output latch. A write to the port address 0x9 loads the output latch.
- R4: A read of the port address 0x9 returns the synchronized pin levels XOR the polarity register.
- R5: `pin_pu` follows the pull-up register.
- R6: A pin with mode bit 0 and enable bit 1 raises the interrupt when its synchronized level differs from the sample of the previous cycle.
- R7: A pin with mode bit 1 and enable bit 1 raises the interrupt while its port value differs from its default-value bit.
- R8: A pin with enable bit 0 never raises the interrupt.
- R9: The flag register at 0x7 holds exactly one set bit while an interrupt is pending. That bit belongs to the lowest-numbered pin that triggered. The flag reads 0 when nothing is pending.
- R10: The capture register at 0x8 latches the port value in the cycle the interrupt is raised. While the interrupt is pending, neither the capture nor the flag changes.
- R11: With configuration bit 0 clear, a read of the port register clears the pending interrupt and a read of the capture register does not.
- R12: With configuration bit 0 set, a read of the capture register clears the pending interrupt and a read of the port register does not.
- R13: Configuration bit 1 makes the interrupt output active-high. Configuration bit 2 selects open-drain: `irq_oe` = 1 and `irq_o` = 0 while the interrupt is pending, and `irq_oe` = 0 otherwise. Open-drain takes precedence over the polarity bit.
- R14: Writes to the flag and capture addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears interrupt on the selected address) |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| pin_in | input | 8 | Pad input levels, asynchronous |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables |
| pin_pu | output | 8 | Pad pull-up enables |
| irq_o | output | 1 | Interrupt output value |
| irq_oe | output | 1 | Interrupt output enable |

## Verification
Every cycle, the embedded assertions check four things. The flag never holds more than one bit. A pending interrupt keeps its flag and capture frozen until acknowledged. An acknowledging read always drops the pending state. A new trigger always raises the interrupt with a flag bit taken from the triggering set. Only the bench's scenarios can show the rest. That covers the choice of which register read acknowledges, the two compare modes against real pin sequences, and the loss of later changes while pending. It also covers the polarity, open-drain and reset values seen at the pads.

// File: rtl/gpio_ioc_port.sv
module gpio_ioc_port #(
  parameter int N      = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [N-1:0]      wdata,
  output logic [N-1:0]      rdata,
  input  logic [N-1:0]      pin_in,
  output logic [N-1:0]      pin_out,
  output logic [N-1:0]      pin_oe,
  output logic [N-1:0]      pin_pu,
  output logic              irq_o,
  output logic              irq_oe
);
  localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(4'h0);
  localparam logic [ADDR_W-1:0] A_POL  = ADDR_W'(4'h1);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(4'h2);
  localparam logic [ADDR_W-1:0] A_DEF  = ADDR_W'(4'h3);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(4'h4);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(4'h5);
  localparam logic [ADDR_W-1:0] A_PU   = ADDR_W'(4'h6);
  localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(4'h7);
  localparam logic [ADDR_W-1:0] A_CAP  = ADDR_W'(4'h8);
  localparam logic [ADDR_W-1:0] A_PORT = ADDR_W'(4'h9);
  localparam logic [ADDR_W-1:0] A_LAT  = ADDR_W'(4'hA);
  localparam int CFG_W = 3;

  logic [N-1:0] dir_q, pol_q, ien_q, def_q, mode_q, pu_q, lat_q;
  logic [CFG_W-1:0] cfg_q;
  logic [N-1:0] sync1_q, sync2_q, prev_q;
  logic [N-1:0] flag_q, cap_q;
  logic         pend_q;

  wire [N-1:0] port_val = sync2_q ^ pol_q;
  wire [N-1:0] diff_prev = sync2_q ^ prev_q;
  wire [N-1:0] diff_def  = port_val ^ def_q;
  wire [N-1:0] trig = ien_q & ((mode_q & diff_def) | (~mode_q & diff_prev));
  wire [N-1:0] first = trig & (~trig + N'(1));
  wire ack_on_cap = cfg_q[0];
  wire ack = rd_en && (addr == (ack_on_cap ? A_CAP : A_PORT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '1;
      pol_q  <= '0;
      ien_q  <= '0;
      def_q  <= '0;
      mode_q <= '0;
      cfg_q  <= '0;
      pu_q   <= '0;
      lat_q  <= '0;
    end else if (wr_en) begin
      case (addr)
        A_DIR:          dir_q  <= wdata;
        A_POL:          pol_q  <= wdata;
        A_IEN:          ien_q  <= wdata;
        A_DEF:          def_q  <= wdata;
        A_MODE:         mode_q <= wdata;
        A_CFG:          cfg_q  <= wdata[CFG_W-1:0];
        A_PU:           pu_q   <= wdata;
        A_PORT, A_LAT:  lat_q  <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      flag_q <= '0;
      cap_q  <= '0;
    end else if (ack) begin
      pend_q <= 1'b0;
      flag_q <= '0;
    end else if (!pend_q && |trig) begin
      pend_q <= 1'b1;
      flag_q <= first;
      cap_q  <= port_val;
    end
  end

  always_comb begin
    case (addr)
      A_DIR:   rdata = dir_q;
      A_POL:   rdata = pol_q;
      A_IEN:   rdata = ien_q;
      A_DEF:   rdata = def_q;
      A_MODE:  rdata = mode_q;
      A_CFG:   rdata = N'(cfg_q);
      A_PU:    rdata = pu_q;
      A_FLAG:  rdata = flag_q;
      A_CAP:   rdata = cap_q;
      A_PORT:  rdata = port_val;
      A_LAT:   rdata = lat_q;
      default: rdata = '0;
    endcase
  end

  assign pin_out = lat_q;
  assign pin_oe  = ~dir_q;
  assign pin_pu  = pu_q;
  assign irq_oe  = cfg_q[2] ? pend_q : 1'b1;
  assign irq_o   = cfg_q[2] ? 1'b0 : (cfg_q[1] ? pend_q : ~pend_q);

  // R9
  flag_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(flag_q));

  // R10
  hold_while_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !ack) |=> ($stable(flag_q) && $stable(cap_q)));

  // R11
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> (flag_q == '0));

  // R6
  raise_on_trigger_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_q && !ack && |trig) |=>
      ((flag_q != '0) && ((flag_q & $past(trig)) == flag_q)));
endmodule

// File: tb/gpio_ioc_port_tb.sv
module gpio_ioc_port_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       wr_en = 0, rd_en = 0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0, rdata, pin_in = '0, pin_out, pin_oe, pin_pu;
  logic       irq_o, irq_oe;

  int checks = 0, fails = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_ioc_port u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .pin_pu(pin_pu), .irq_o(irq_o), .irq_oe(irq_oe)
  );

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string tag);
    @(negedge clk); rd_en = 1; addr = a; exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); rd_en = 0;
  endtask

  task automatic chk(input logic [7:0] act, input logic [7:0] e, input string tag);
    checks++;
    if (act !== e) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, e);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      if (rd_en) begin
        if (exp_q.size() == 0) begin
          fails++; $display("FAIL scoreboard: read with no expected item");
        end else begin
          chk(rdata, exp_q.pop_front(), tag_q.pop_front());
        end
      end
    end
  end

  task automatic run();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(4'h0, 8'hFF, "R1 dir");
    rd(4'h1, 8'h00, "R1 pol");
    rd(4'h2, 8'h00, "R1 ien");
    rd(4'h5, 8'h00, "R1 cfg");
    rd(4'hA, 8'h00, "R1 latch");
    chk(pin_oe, 8'h00, "R1 pin_oe");
    chk({7'd0, irq_o}, 8'h01, "R1 irq_o");
    chk({7'd0, irq_oe}, 8'h01, "R1 irq_oe");
    // R3 R5 R2
    wr(4'h0, 8'hF0); wr(4'hA, 8'h5A);
    @(negedge clk);
    chk(pin_oe, 8'h0F, "R3 pin_oe");
    chk(pin_out, 8'h5A, "R3 pin_out");
    wr(4'h9, 8'h33);
    rd(4'hA, 8'h33, "R3 port write loads latch");
    wr(4'h6, 8'hC3);
    @(negedge clk);
    chk(pin_pu, 8'hC3, "R5 pin_pu");
    rd(4'h6, 8'hC3, "R2 pullup readback");
    wr(4'h5, 8'hFF);
    rd(4'h5, 8'h07, "R2 cfg keeps 3 bits");
    wr(4'h5, 8'h00);
    wr(4'h3, 8'h6C);
    rd(4'h3, 8'h6C, "R2 default readback");
    wr(4'h3, 8'h00);
    // R4
    pin_in = 8'hA5; settle();
    rd(4'h9, 8'hA5, "R4 port");
    wr(4'h1, 8'h0F);
    rd(4'h9, 8'hAA, "R4 port inverted");
    wr(4'h1, 8'h00);
    rd(4'h7, 8'h00, "R8 no irq with enables off");
    // R6 R8 R9 R10 R11
    wr(4'h2, 8'h30);
    pin_in = 8'hA4; settle();
    rd(4'h7, 8'h00, "R8 disabled pin ignored");
    chk({7'd0, irq_o}, 8'h01, "R8 irq inactive");
    pin_in = 8'h94; settle();
    chk({7'd0, irq_o}, 8'h00, "R13 active-low asserted");
    rd(4'h7, 8'h10, "R9 lowest pin flagged");
    rd(4'h8, 8'h94, "R10 capture");
    chk({7'd0, irq_o}, 8'h00, "R11 capture read keeps pending");
    pin_in = 8'hB4; settle();
    rd(4'h8, 8'h94, "R10 capture frozen");
    rd(4'h7, 8'h10, "R10 flag frozen");
    rd(4'h9, 8'hB4, "R11 port read");
    @(negedge clk);
    chk({7'd0, irq_o}, 8'h01, "R11 cleared by port read");
    rd(4'h7, 8'h00, "R11 flag cleared");
    // R7 R12
    wr(4'h4, 8'h01); wr(4'h2, 8'h01);
    settle();
    rd(4'h7, 8'h00, "R7 match no irq");
    pin_in = 8'hB5; settle();
    rd(4'h7, 8'h01, "R7 default mismatch flag");
    rd(4'h8, 8'hB5, "R7 capture");
    wr(4'h5, 8'h01);
    rd(4'h9, 8'hB5, "R12 port read");
    @(negedge clk);
    chk({7'd0, irq_o}, 8'h00, "R12 port read keeps pending");
    pin_in = 8'hB4; settle();
    rd(4'h8, 8'hB5, "R12 capture read");
    @(negedge clk);
    chk({7'd0, irq_o}, 8'h01, "R12 cleared by capture read");
    rd(4'h7, 8'h00, "R12 flag cleared");
    // R13
    wr(4'h5, 8'h02);
    chk({7'd0, irq_o}, 8'h00, "R13 active-high idle");
    pin_in = 8'hB5; settle();
    chk({7'd0, irq_o}, 8'h01, "R13 active-high asserted");
    wr(4'h5, 8'h06);
    chk({7'd0, irq_oe}, 8'h01, "R13 open-drain drives");
    chk({7'd0, irq_o}, 8'h00, "R13 open-drain low");
    pin_in = 8'hB4; settle();
    wr(4'h5, 8'h04);
    rd(4'h9, 8'hB4, "R13 port read ack");
    @(negedge clk);
    chk({7'd0, irq_oe}, 8'h00, "R13 open-drain released");
    // R14
    wr(4'h7, 8'hFF); wr(4'h8, 8'hFF);
    rd(4'h7, 8'h00, "R14 flag write ignored");
    rd(4'h8, 8'hB5, "R14 capture write ignored");
    repeat (3) @(negedge clk);
  endtask

  initial begin
    fork
      run();
      begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule